// File: doc/BRIEF.md
# Sticky Boot-Complete Status Register

This block holds one status flag per processor core in a 32-bit memory-mapped register. Boot firmware on each core writes a 1 to its own flag just before it hands control to application code. A flag that has been set stays set until the next device reset, and software cannot clear it. A warm reset or a power-on reset clears every flag.

There are eight signal-processing cores and four general-purpose cores. The signal-processing cores use flags 0 to 7 and the general-purpose cores use flags 8 to 11. A parameter selects the full variant or the reduced variant. On the reduced variant, only signal-processing cores 0 to 3 and general-purpose cores 0 to 1 exist, so flags 11, 10 and 7:4 are tied to zero.

A registered output pin goes high once every flag that belongs to a present core is set. External logic can watch this pin to learn that the whole device has finished booting. The register port is a plain single-cycle select/write port with byte strobes. It has no back-pressure, because every access completes in the cycle it is presented. Read data appears on the cycle after a read select.

Top module: `bootdone_status_reg`

## Requirements
- R1: After a power-on reset, `reg_rdata` is 0, `boot_done` is 0 and all flags read as 0.
- R2: A write at `REG_ADDR` sets every flag whose `reg_wdata` bit is 1, at the write's clock edge. A read select at `REG_ADDR` returns the flags in `reg_rdata[11:0]` on the next cycle.
- R3: Writing 0 to a flag that is set leaves it set. Writing 1 again has no further effect.
- R4: A warm reset or a power-on reset clears all flags and `boot_done` at the next clock edge.
- R5: When a write and a warm reset fall in the same cycle, the reset wins and all flags end up at 0.
- R6: Bits 31:12 always read as 0, and writes to them are ignored.
- R7: `reg_strb[0]` gates the write to flags 7:0 and `reg_strb[1]` gates the write to flags 11:8. Flags in a byte whose strobe is low keep their value.
- R8: A write has no effect when it goes to any address other than `REG_ADDR`, when `reg_sel` is low, or when `reg_wr` is low.
- R9: With `FULL_VARIANT = 0`, flags 11, 10 and 7:4 read as 0 and ignore writes.
- R10: `boot_done` rises one cycle after the clock edge that sets the last flag of a present core. It is never high while a present core's flag is clear.
- R11: `reg_rdata` is 0 on every cycle that does not follow a read select at `REG_ADDR`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| warm_rst | input | 1 | Warm reset, synchronous, active high |
| reg_sel | input | 1 | Access select |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W (8) | Access address |
| reg_wdata | input | 32 | Write data |
| reg_strb | input | 4 | Byte write strobes |
| reg_rdata | output | 32 | Read data, valid the cycle after a read select |
| boot_done | output | 1 | High when all present cores have reported boot completion |

## Verification
The assertions assume that both resets are synchronous and that `por_rst` is held for at least one clock edge before any access. They also assume that all inputs are stable around the rising edge. The bench meets these assumptions by holding `por_rst` for several cycles at start-up and by driving every input only on the falling edge. One stimulus stream feeds a full-variant instance and a reduced-variant instance at the same time, so the masking shows up as a difference between their outputs under identical writes.

// File: rtl/bootdone_pkg.sv
package bootdone_pkg;
  localparam int REG_W  = 32;
  localparam int BYTE_W = 8;
  localparam int STRB_W = REG_W / BYTE_W;

  typedef logic [REG_W-1:0] reg_word_t;
endpackage

// File: rtl/bootdone_mask.sv
module bootdone_mask
  import bootdone_pkg::*;
#(
  parameter int NUM_DSP      = 8,
  parameter int NUM_GP       = 4,
  parameter int DSP_REDUCED  = 4,
  parameter int GP_REDUCED   = 2,
  parameter bit FULL_VARIANT = 1'b1
) (
  output reg_word_t present_o
);
  localparam int GP_BASE = NUM_DSP;
  localparam int FLAG_W  = NUM_DSP + NUM_GP;

  // One bit per existing core; reserved positions stay zero.
  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (i < GP_BASE) begin : g_dsp
      assign present_o[i] = FULL_VARIANT ? 1'b1 : (i < DSP_REDUCED);
    end else if (i < FLAG_W) begin : g_gp
      assign present_o[i] = FULL_VARIANT ? 1'b1 : ((i - GP_BASE) < GP_REDUCED);
    end else begin : g_rsvd
      assign present_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/bootdone_flags.sv
module bootdone_flags
  import bootdone_pkg::*;
(
  input  logic      clk,
  input  logic      rst_any,
  input  logic      wr_hit,
  input  reg_word_t wdata,
  input  reg_word_t bit_en,
  input  reg_word_t present,
  output reg_word_t flags_o
);
  reg_word_t flags_q;
  reg_word_t set_req;

  always_comb begin
    set_req = '0;
    if (wr_hit) set_req = wdata & bit_en & present;
  end

  always_ff @(posedge clk) begin
    if (rst_any) flags_q <= '0;
    else         flags_q <= flags_q | set_req;
  end

  assign flags_o = flags_q;

  // R3
  flags_sticky_chk: assert property (@(posedge clk) disable iff (rst_any)
    1'b1 |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  // R4
  flags_reset_chk: assert property (@(posedge clk)
    rst_any |=> (flags_q == '0));
  // R9
  absent_bits_chk: assert property (@(posedge clk) disable iff (rst_any)
    ((flags_q & ~present) == '0));
  // R8
  no_write_no_change_chk: assert property (@(posedge clk) disable iff (rst_any)
    !wr_hit |=> (flags_q == $past(flags_q)));
endmodule

// File: rtl/bootdone_rdport.sv
module bootdone_rdport
  import bootdone_pkg::*;
#(
  parameter int FLAG_W = 12
) (
  input  logic      clk,
  input  logic      rst_any,
  input  logic      rd_hit,
  input  reg_word_t flags,
  output reg_word_t rdata_o
);
  reg_word_t rdata_q;

  always_ff @(posedge clk) begin
    if (rst_any)     rdata_q <= '0;
    else if (rd_hit) rdata_q <= flags;
    else             rdata_q <= '0;
  end

  assign rdata_o = rdata_q;

  // R6
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst_any)
    (rdata_q[REG_W-1:FLAG_W] == '0));
  // R11
  idle_rdata_chk: assert property (@(posedge clk) disable iff (rst_any)
    !rd_hit |=> (rdata_q == '0));
endmodule

// File: rtl/bootdone_pin.sv
module bootdone_pin
  import bootdone_pkg::*;
(
  input  logic      clk,
  input  logic      rst_any,
  input  reg_word_t flags,
  input  reg_word_t present,
  output logic      done_o
);
  logic done_q;

  always_ff @(posedge clk) begin
    if (rst_any) done_q <= 1'b0;
    else         done_q <= ((flags & present) == present);
  end

  assign done_o = done_q;

  // R10
  pin_implies_flags_chk: assert property (@(posedge clk) disable iff (rst_any)
    done_q |-> ((flags & present) == present));
endmodule

// File: rtl/bootdone_status_reg.sv
module bootdone_status_reg
  import bootdone_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter logic [7:0]  REG_ADDR     = 8'h3C,
  parameter int          NUM_DSP      = 8,
  parameter int          NUM_GP       = 4,
  parameter int          DSP_REDUCED  = 4,
  parameter int          GP_REDUCED   = 2,
  parameter bit          FULL_VARIANT = 1'b1
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              warm_rst,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic [3:0]        reg_strb,
  output logic [31:0]       reg_rdata,
  output logic              boot_done
);
  localparam int FLAG_W = NUM_DSP + NUM_GP;

  logic      rst_any;
  logic      addr_hit;
  logic      wr_hit;
  logic      rd_hit;
  reg_word_t bit_en;
  reg_word_t present;
  reg_word_t flags;

  assign rst_any  = por_rst | warm_rst;
  assign addr_hit = reg_sel && (reg_addr == REG_ADDR[ADDR_W-1:0]);
  assign wr_hit   = addr_hit && reg_wr;
  assign rd_hit   = addr_hit && !reg_wr;

  // Expand the byte strobes into one enable per bit.
  for (genvar b = 0; b < REG_W; b++) begin : g_en
    assign bit_en[b] = reg_strb[b / BYTE_W];
  end

  bootdone_mask #(
    .NUM_DSP(NUM_DSP), .NUM_GP(NUM_GP), .DSP_REDUCED(DSP_REDUCED),
    .GP_REDUCED(GP_REDUCED), .FULL_VARIANT(FULL_VARIANT)
  ) u_mask (
    .present_o(present)
  );

  bootdone_flags u_flags (
    .clk(clk), .rst_any(rst_any), .wr_hit(wr_hit), .wdata(reg_wdata),
    .bit_en(bit_en), .present(present), .flags_o(flags)
  );

  bootdone_rdport #(.FLAG_W(FLAG_W)) u_rd (
    .clk(clk), .rst_any(rst_any), .rd_hit(rd_hit), .flags(flags),
    .rdata_o(reg_rdata)
  );

  bootdone_pin u_pin (
    .clk(clk), .rst_any(rst_any), .flags(flags), .present(present),
    .done_o(boot_done)
  );
endmodule

// File: tb/bootdone_status_reg_tb.sv
module bootdone_status_reg_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A = 8'h3C;

  logic clk = 1'b0;
  logic por_rst, warm_rst, reg_sel, reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [3:0]  reg_strb;
  logic [31:0] rdata [2];
  logic        done  [2];

  int checks = 0;
  int fails  = 0;
  bit started = 0;
  bit finished = 0;

  int m_flags [2];
  int m_rd    [2];
  int m_pin   [2];
  int msk     [2] = '{32'hFFF, 32'h30F};

  always #(CLK_PERIOD/2) clk = ~clk;

  bootdone_status_reg #(.FULL_VARIANT(1'b1)) u_dut (
    .clk(clk), .por_rst(por_rst), .warm_rst(warm_rst), .reg_sel(reg_sel),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_strb(reg_strb), .reg_rdata(rdata[0]), .boot_done(done[0]));

  bootdone_status_reg #(.FULL_VARIANT(1'b0)) u_dut_red (
    .clk(clk), .por_rst(por_rst), .warm_rst(warm_rst), .reg_sel(reg_sel),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_strb(reg_strb), .reg_rdata(rdata[1]), .boot_done(done[1]));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Behavioural reference: advances on each rising edge.
  always @(posedge clk) begin
    started = 1;
    for (int d = 0; d < 2; d++) begin
      if (por_rst || warm_rst) begin
        m_flags[d] = 0; m_pin[d] = 0; m_rd[d] = 0;
      end else begin
        m_pin[d] = ((m_flags[d] & msk[d]) == msk[d]) ? 1 : 0;
        m_rd[d]  = (reg_sel && !reg_wr && reg_addr == A) ? m_flags[d] : 0;
        if (reg_sel && reg_wr && reg_addr == A) begin
          if (reg_strb[0]) m_flags[d] = m_flags[d] | (reg_wdata & 32'h0FF & msk[d]);
          if (reg_strb[1]) m_flags[d] = m_flags[d] | (reg_wdata & 32'hF00 & msk[d]);
        end
      end
    end
  end

  // Compare on every falling edge (R2 read data, R10 pin).
  always @(negedge clk) begin
    if (started && !finished) begin
      for (int d = 0; d < 2; d++) begin
        check($sformatf("R2 model rdata dut%0d", d), rdata[d], m_rd[d]);
        check($sformatf("R10 model pin dut%0d", d), {31'b0, done[d]}, m_pin[d]);
      end
    end
  end

  task automatic idle();
    reg_sel = 0; reg_wr = 0; reg_addr = A; reg_wdata = '0; reg_strb = '0;
  endtask

  task automatic bus_write(input logic [7:0] ad, input logic [31:0] wd, input logic [3:0] st);
    reg_sel = 1; reg_wr = 1; reg_addr = ad; reg_wdata = wd; reg_strb = st;
    @(negedge clk);
    idle();
  endtask

  task automatic bus_read(output logic [31:0] r0, output logic [31:0] r1);
    reg_sel = 1; reg_wr = 0; reg_addr = A; reg_strb = '0;
    @(negedge clk);
    r0 = rdata[0]; r1 = rdata[1];
    idle();
  endtask

  task automatic finish_up();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] r0, r1;
    por_rst = 1; warm_rst = 0; idle();
    repeat (3) @(negedge clk);
    por_rst = 0;
    // R1 reset state
    check("R1 rdata after por", rdata[0], 32'h0);
    check("R1 pin after por", {31'b0, done[0]}, 32'h0);
    bus_read(r0, r1);
    check("R1 flags after por", r0, 32'h0);

    // R2 set a flag
    bus_write(A, 32'h001, 4'b0001);
    bus_read(r0, r1);
    check("R2 set flag0", r0, 32'h001);
    check("R2 set flag0 reduced", r1, 32'h001);

    // R3 write zero does not clear
    bus_write(A, 32'h000, 4'b0011);
    bus_write(A, 32'h001, 4'b0011);
    bus_read(r0, r1);
    check("R3 sticky", r0, 32'h001);

    // R6 reserved bits
    bus_write(A, 32'hFFFF_F000, 4'b1100);
    bus_read(r0, r1);
    check("R6 reserved ignored", r0, 32'h001);

    // R7 byte strobes
    bus_write(A, 32'h0F0, 4'b0010);
    bus_read(r0, r1);
    check("R7 strobe0 low blocks low byte", r0, 32'h001);
    bus_write(A, 32'h300, 4'b0001);
    bus_read(r0, r1);
    check("R7 strobe1 low blocks high bits", r0, 32'h001);
    bus_write(A, 32'h300, 4'b0010);
    bus_read(r0, r1);
    check("R7 strobe1 sets high bits", r0, 32'h301);

    // R8 ignored accesses
    bus_write(8'h40, 32'h0FE, 4'b1111);
    reg_sel = 0; reg_wr = 1; reg_addr = A; reg_wdata = 32'h0FE; reg_strb = 4'hF;
    @(negedge clk); idle();
    bus_read(r0, r1);
    check("R8 other address and no select", r0, 32'h301);

    // R9 / R10 variant masking and pin timing
    bus_write(A, 32'hFFF, 4'b0001);
    check("R10 pin not yet high", {31'b0, done[1]}, 32'h0);
    @(negedge clk);
    check("R10 reduced pin high", {31'b0, done[1]}, 32'h1);
    check("R10 full pin low", {31'b0, done[0]}, 32'h0);
    bus_read(r0, r1);
    check("R9 full flags", r0, 32'h3FF);
    check("R9 reduced flags masked", r1, 32'h30F);

    // R11 idle read data
    @(negedge clk);
    check("R11 idle rdata", rdata[0], 32'h0);

    // R4 / R5 warm reset beats write
    warm_rst = 1;
    reg_sel = 1; reg_wr = 1; reg_addr = A; reg_wdata = 32'hC00; reg_strb = 4'b0010;
    @(negedge clk);
    warm_rst = 0; idle();
    check("R4 pin cleared by warm reset", {31'b0, done[1]}, 32'h0);
    bus_read(r0, r1);
    check("R5 reset wins over write", r0, 32'h0);

    // R10 full variant pin, then R4 power-on reset
    bus_write(A, 32'hFFF, 4'b0011);
    @(negedge clk);
    check("R10 full pin high", {31'b0, done[0]}, 32'h1);
    por_rst = 1;
    @(negedge clk);
    por_rst = 0;
    check("R4 pin cleared by por", {31'b0, done[0]}, 32'h0);
    bus_read(r0, r1);
    check("R4 flags cleared by por", r0, 32'h0);

    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule